// File: doc/BRIEF.md
# Nibble-Field Register Processor

A small multicycle processor core for a toy 16-bit instruction set. A single array of sixteen 32-bit words holds both program and data, and a file of fifteen 8-bit registers holds working values. Every instruction takes two cycles: one to fetch the word at the program counter and one to execute it. The instruction word carries a 4-bit opcode in its top nibble and two 4-bit operand fields below it. The lowest nibble is always zero.

Register operands are numbered from one: an operand field of value n selects register r(n-1). Field value 0 means "no register". The two highest fields select the status placeholder register and the stack pointer. Execution starts at word 4 and stops for good once the program counter points past the last memory word.

A load port fills the memory while the core is paused. Two combinational read ports expose any register (selected with the operand-field encoding) and any memory word, so a test environment can inspect the results.

Top module: `nib_core`

## Requirements
- R1: After reset the program counter is 4. Each instruction spends one fetch cycle and one execute cycle. The fetch cycle latches the low 16 bits of the addressed word. Every executed instruction other than jmp leaves the counter one higher.
- R2: A register operand field of value n (1..15) selects register r(n-1). Field 14 is the status register and field 15 is the stack pointer. Field 0 reads as 0, and writes to it are discarded. The debug register select uses the same encoding.
- R3: Opcode 1 (add), 2 (sub), 3 (or) and 4 (and) combine the register in bits [11:8] with the register in bits [7:4] and write the result, modulo 256, to the register in bits [11:8].
- R4: Opcode 10 (mov) copies the register in bits [7:4] into the register in bits [11:8].
- R5: Opcode 8 (ldi) writes the 4-bit literal in bits [7:4], zero-extended, into the register in bits [11:8].
- R6: Opcode 9 (lds) writes the low 8 bits of the memory word addressed by bits [7:4] into the register in bits [11:8].
- R7: Opcode 11 (st) writes the register selected by bits [7:4], zero-extended to 32 bits, into the memory word addressed by bits [11:8].
- R8: Opcode 7 (jmp) loads the program counter with the 8-bit field in bits [11:4].
- R9: Opcode 5 (push) decrements the stack pointer modulo 256 and stores r0, zero-extended, at the word addressed by the low 4 bits of the new value. Opcode 6 (pop) loads r0 from the low 8 bits of the word addressed by the stack pointer and then increments the stack pointer.
- R10: When a fetch finds the program counter above 15, the core enters a halted state. `halted` goes high, and from then on neither the counter, the registers nor the memory change until reset.
- R11: While `halt_req` is high the core does not advance: the counter, state, registers and memory hold their values.
- R12: Opcode 0 and the unused opcodes 12 to 15 change no register and no memory word. They only advance the program counter.
- R13: Reset clears every register and memory word. A load-port write stores `ld_data` at `ld_addr` on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| halt_req | input | 1 | Pause request; the core holds while high |
| ld_en | input | 1 | Load-port write enable |
| ld_addr | input | 4 | Load-port word address |
| ld_data | input | 32 | Load-port write data |
| dbg_reg_sel | input | 4 | Register select, operand-field encoding |
| dbg_reg_val | output | 8 | Value of the selected register |
| dbg_mem_sel | input | 4 | Memory word select |
| dbg_mem_val | output | 32 | Value of the selected memory word |
| pc_out | output | 8 | Program counter |
| halted | output | 1 | High once the core has run off the end of memory |

## Verification
Each short program is loaded into words 4 to 7. The remaining words are filled with data whose upper 24 bits are non-zero and whose low byte repeats the word number, and which decodes as an unused opcode. This makes truncation on lds and zero-extension on st visible, and it also exercises the unused-opcode path.

The programs are chosen to separate specific faults:
- Sum overflow and difference underflow separate correct wrapping from saturation or sign handling.
- An and followed by an or on distinct bit patterns would expose swapped opcodes.
- Programs that write through field 0, and that address the status register and the stack pointer, expose an off-by-one in the operand decode.
- A jump over a live instruction, a jump past the end of memory, and a push/pop round trip cover control flow and the stack.

Directed steps check the reset state, the pause input, and the exact cycle in which the counter first moves.

// File: rtl/nib_pkg.sv
package nib_pkg;

  localparam int unsigned FIELD_W = 4;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_SUB  = 4'd2,
    OP_OR   = 4'd3,
    OP_AND  = 4'd4,
    OP_PUSH = 4'd5,
    OP_POP  = 4'd6,
    OP_JMP  = 4'd7,
    OP_LDI  = 4'd8,
    OP_LDS  = 4'd9,
    OP_MOV  = 4'd10,
    OP_ST   = 4'd11
  } nib_op_e;

  typedef enum logic [1:0] {
    S_FETCH = 2'd0,
    S_EXEC  = 2'd1,
    S_HALT  = 2'd2
  } nib_state_e;

endpackage

// File: rtl/nib_rst_sync.sv
module nib_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/nib_regfile.sv
module nib_regfile
  import nib_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned NENT = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] rd_sel,
  input  logic [FIELD_W-1:0] rs_sel,
  input  logic [FIELD_W-1:0] dbg_sel,
  output logic [DW-1:0]      rd_val,
  output logic [DW-1:0]      rs_val,
  output logic [DW-1:0]      dbg_val,
  output logic [DW-1:0]      r0_val,
  output logic [DW-1:0]      sp_val,
  input  logic               we,
  input  logic [FIELD_W-1:0] wsel,
  input  logic [DW-1:0]      wdata,
  input  logic               sp_we,
  input  logic [DW-1:0]      sp_wdata
);

  localparam int unsigned SP_IDX = NENT - 1;

  logic [DW-1:0] ent_q [NENT];

  function automatic logic [DW-1:0] read_field(input logic [FIELD_W-1:0] f);
    logic [FIELD_W-1:0] idx;
    idx = f - FIELD_W'(1);
    if (f == '0) begin
      return '0;
    end
    return ent_q[idx];
  endfunction

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    logic hit_w;
    logic hit_sp;
    logic en;
    logic [DW-1:0] d;
    assign hit_w  = we && (wsel == FIELD_W'(i + 1));
    assign hit_sp = sp_we && (i == SP_IDX);
    assign en     = hit_w || hit_sp;
    assign d      = hit_sp ? sp_wdata : wdata;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[i] <= '0;
      end else if (en) begin
        ent_q[i] <= d;
      end
    end
  end

  always_comb begin
    rd_val  = read_field(rd_sel);
    rs_val  = read_field(rs_sel);
    dbg_val = read_field(dbg_sel);
    r0_val  = ent_q[0];
    sp_val  = ent_q[SP_IDX];
  end

endmodule

// File: rtl/nib_mem.sv
module nib_mem #(
  parameter int unsigned MW = 32,
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [MW-1:0] ld_data,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [MW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [MW-1:0] rdata,
  input  logic [AW-1:0] dbg_addr,
  output logic [MW-1:0] dbg_rdata
);

  localparam int unsigned DEPTH = 2 ** AW;

  logic [MW-1:0] word_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic ld_hit;
    logic core_hit;
    logic en;
    logic [MW-1:0] d;
    assign ld_hit   = ld_en && (ld_addr == AW'(i));
    assign core_hit = we && (waddr == AW'(i));
    assign en       = ld_hit || core_hit;
    assign d        = ld_hit ? ld_data : wdata;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[i] <= '0;
      end else if (en) begin
        word_q[i] <= d;
      end
    end
  end

  always_comb begin
    rdata     = word_q[raddr];
    dbg_rdata = word_q[dbg_addr];
  end

endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_OR:   y = a | b;
      OP_AND:  y = a & b;
      default: y = b;
    endcase
  end

endmodule

// File: rtl/nib_ctrl.sv
module nib_ctrl
  import nib_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned MW       = 32,
  parameter int unsigned AW       = 4,
  parameter int unsigned IW       = 16,
  parameter int unsigned PCW      = 8,
  parameter int unsigned RESET_PC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_req,
  input  logic [MW-1:0]      mem_rdata,
  input  logic [DW-1:0]      rs_val,
  input  logic [DW-1:0]      r0_val,
  input  logic [DW-1:0]      sp_val,
  input  logic [DW-1:0]      alu_y,
  output nib_state_e         state_q,
  output logic [PCW-1:0]     pc_q,
  output logic [IW-1:0]      ir_q,
  output logic [3:0]         op,
  output logic [FIELD_W-1:0] fa,
  output logic [FIELD_W-1:0] fb,
  output logic [AW-1:0]      mem_raddr,
  output logic               mem_we,
  output logic [AW-1:0]      mem_waddr,
  output logic [MW-1:0]      mem_wdata,
  output logic               rf_we,
  output logic [FIELD_W-1:0] rf_wsel,
  output logic [DW-1:0]      rf_wdata,
  output logic               sp_we,
  output logic [DW-1:0]      sp_wdata
);

  localparam logic [PCW-1:0] LAST_PC  = PCW'(2 ** AW - 1);
  localparam logic [PCW-1:0] START_PC = PCW'(RESET_PC);

  nib_state_e     state_d;
  logic [PCW-1:0] pc_d;
  logic [IW-1:0]  ir_d;
  logic           run;
  logic           exec;
  logic           ir_en;
  logic           pc_en;

  assign run  = !halt_req;
  assign op   = ir_q[IW-1 -: 4];
  assign fa   = ir_q[IW-5 -: FIELD_W];
  assign fb   = ir_q[IW-9 -: FIELD_W];
  assign exec = run && (state_q == S_EXEC);

  // sequencing
  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    ir_d    = ir_q;
    ir_en   = 1'b0;
    pc_en   = 1'b0;
    case (state_q)
      S_FETCH: begin
        if (pc_q > LAST_PC) begin
          state_d = S_HALT;
        end else begin
          state_d = S_EXEC;
          ir_d    = mem_rdata[IW-1:0];
          ir_en   = 1'b1;
        end
      end
      S_EXEC: begin
        state_d = S_FETCH;
        pc_en   = 1'b1;
        if (op == OP_JMP) begin
          pc_d = PCW'(ir_q[IW-5 -: 8]);
        end else begin
          pc_d = pc_q + PCW'(1);
        end
      end
      default: state_d = S_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_FETCH;
    end else if (run) begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= START_PC;
    end else if (run && pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= '0;
    end else if (run && ir_en) begin
      ir_q <= ir_d;
    end
  end

  // execute-stage datapath control
  always_comb begin
    mem_raddr = fb;
    if (state_q == S_FETCH) begin
      mem_raddr = pc_q[AW-1:0];
    end else if (op == OP_POP) begin
      mem_raddr = sp_val[AW-1:0];
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = '0;
    mem_wdata = '0;
    rf_we     = 1'b0;
    rf_wsel   = fa;
    rf_wdata  = '0;
    sp_we     = 1'b0;
    sp_wdata  = sp_val;
    if (exec) begin
      case (op)
        OP_ADD, OP_SUB, OP_OR, OP_AND, OP_MOV: begin
          rf_we    = 1'b1;
          rf_wdata = alu_y;
        end
        OP_LDI: begin
          rf_we    = 1'b1;
          rf_wdata = DW'(fb);
        end
        OP_LDS: begin
          rf_we    = 1'b1;
          rf_wdata = mem_rdata[DW-1:0];
        end
        OP_POP: begin
          rf_we    = 1'b1;
          rf_wsel  = FIELD_W'(1);
          rf_wdata = mem_rdata[DW-1:0];
          sp_we    = 1'b1;
          sp_wdata = sp_val + DW'(1);
        end
        OP_PUSH: begin
          sp_we     = 1'b1;
          sp_wdata  = sp_val - DW'(1);
          mem_we    = 1'b1;
          mem_waddr = sp_wdata[AW-1:0];
          mem_wdata = MW'(r0_val);
        end
        OP_ST: begin
          mem_we    = 1'b1;
          mem_waddr = AW'(fa);
          mem_wdata = MW'(rs_val);
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/nib_core.sv
module nib_core
  import nib_pkg::*;
#(
  parameter int unsigned DW       = 8,
  parameter int unsigned MW       = 32,
  parameter int unsigned AW       = 4,
  parameter int unsigned IW       = 16,
  parameter int unsigned PCW      = 8,
  parameter int unsigned NREG     = 15,
  parameter int unsigned RESET_PC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               halt_req,
  input  logic               ld_en,
  input  logic [AW-1:0]      ld_addr,
  input  logic [MW-1:0]      ld_data,
  input  logic [FIELD_W-1:0] dbg_reg_sel,
  output logic [DW-1:0]      dbg_reg_val,
  input  logic [AW-1:0]      dbg_mem_sel,
  output logic [MW-1:0]      dbg_mem_val,
  output logic [PCW-1:0]     pc_out,
  output logic               halted
);

  logic               rst_core_n;
  nib_state_e         state_q;
  logic [PCW-1:0]     pc_q;
  logic [IW-1:0]      ir_q;
  logic [3:0]         op;
  logic [FIELD_W-1:0] fa;
  logic [FIELD_W-1:0] fb;
  logic [DW-1:0]      rd_val;
  logic [DW-1:0]      rs_val;
  logic [DW-1:0]      r0_val;
  logic [DW-1:0]      sp_val;
  logic [DW-1:0]      alu_y;
  logic [AW-1:0]      mem_raddr;
  logic [MW-1:0]      mem_rdata;
  logic               mem_we;
  logic [AW-1:0]      mem_waddr;
  logic [MW-1:0]      mem_wdata;
  logic               rf_we;
  logic [FIELD_W-1:0] rf_wsel;
  logic [DW-1:0]      rf_wdata;
  logic               sp_we;
  logic [DW-1:0]      sp_wdata;

  nib_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  nib_ctrl #(
    .DW(DW), .MW(MW), .AW(AW), .IW(IW), .PCW(PCW), .RESET_PC(RESET_PC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .halt_req  (halt_req),
    .mem_rdata (mem_rdata),
    .rs_val    (rs_val),
    .r0_val    (r0_val),
    .sp_val    (sp_val),
    .alu_y     (alu_y),
    .state_q   (state_q),
    .pc_q      (pc_q),
    .ir_q      (ir_q),
    .op        (op),
    .fa        (fa),
    .fb        (fb),
    .mem_raddr (mem_raddr),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .rf_we     (rf_we),
    .rf_wsel   (rf_wsel),
    .rf_wdata  (rf_wdata),
    .sp_we     (sp_we),
    .sp_wdata  (sp_wdata)
  );

  nib_regfile #(.DW(DW), .NENT(NREG)) u_rf (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rd_sel   (fa),
    .rs_sel   (fb),
    .dbg_sel  (dbg_reg_sel),
    .rd_val   (rd_val),
    .rs_val   (rs_val),
    .dbg_val  (dbg_reg_val),
    .r0_val   (r0_val),
    .sp_val   (sp_val),
    .we       (rf_we),
    .wsel     (rf_wsel),
    .wdata    (rf_wdata),
    .sp_we    (sp_we),
    .sp_wdata (sp_wdata)
  );

  nib_alu #(.DW(DW)) u_alu (
    .op (op),
    .a  (rd_val),
    .b  (rs_val),
    .y  (alu_y)
  );

  nib_mem #(.MW(MW), .AW(AW)) u_mem (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .ld_en     (ld_en),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .we        (mem_we),
    .waddr     (mem_waddr),
    .wdata     (mem_wdata),
    .raddr     (mem_raddr),
    .rdata     (mem_rdata),
    .dbg_addr  (dbg_mem_sel),
    .dbg_rdata (dbg_mem_val)
  );

  assign pc_out = pc_q;
  assign halted = (state_q == S_HALT);

endmodule

// File: rtl/nib_core_chk.sv
module nib_core_chk
  import nib_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned AW  = 4,
  parameter int unsigned IW  = 16,
  parameter int unsigned PCW = 8
) (
  input logic               clk,
  input logic               rst_core_n,
  input logic               halt_req,
  input nib_state_e         state_q,
  input logic [PCW-1:0]     pc_q,
  input logic [IW-1:0]      ir_q,
  input logic [DW-1:0]      sp_val,
  input logic               halted,
  input logic [FIELD_W-1:0] dbg_reg_sel,
  input logic [DW-1:0]      dbg_reg_val
);

  localparam logic [PCW-1:0] LAST_PC = PCW'(2 ** AW - 1);

  logic [3:0] op_c;
  assign op_c = ir_q[IW-1 -: 4];

  p_pc_step_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q == S_EXEC && !halt_req && op_c != OP_JMP) |=> (pc_q == $past(pc_q) + PCW'(1)));

  p_fetch_exec_r1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q == S_FETCH && !halt_req && pc_q <= LAST_PC) |=> (state_q == S_EXEC));

  p_none_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (dbg_reg_sel == '0) |-> (dbg_reg_val == '0));

  p_jmp_target_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q == S_EXEC && !halt_req && op_c == OP_JMP) |=> (pc_q == PCW'($past(ir_q[IW-5 -: 8]))));

  p_push_sp_r9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state_q == S_EXEC && !halt_req && op_c == OP_PUSH) |=> (sp_val == $past(sp_val) - DW'(1)));

  p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    halted |=> (halted && $stable(pc_q)));

  p_pause_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    halt_req |=> ($stable(pc_q) && $stable(state_q) && $stable(sp_val)));

endmodule

bind nib_core nib_core_chk #(.DW(DW), .AW(AW), .IW(IW), .PCW(PCW)) u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .halt_req    (halt_req),
  .state_q     (state_q),
  .pc_q        (pc_q),
  .ir_q        (ir_q),
  .sp_val      (sp_val),
  .halted      (halted),
  .dbg_reg_sel (dbg_reg_sel),
  .dbg_reg_val (dbg_reg_val)
);

// File: tb/nib_core_bench.sv
module nib_core_bench;

  logic        clk;
  logic        rst_n;
  logic        halt_req;
  logic        ld_en;
  logic [3:0]  ld_addr;
  logic [31:0] ld_data;
  logic [3:0]  dbg_reg_sel;
  logic [7:0]  dbg_reg_val;
  logic [3:0]  dbg_mem_sel;
  logic [31:0] dbg_mem_val;
  logic [7:0]  pc_out;
  logic        halted;

  int checks;
  int errors;

  nib_core u_nib_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_req    (halt_req),
    .ld_en       (ld_en),
    .ld_addr     (ld_addr),
    .ld_data     (ld_data),
    .dbg_reg_sel (dbg_reg_sel),
    .dbg_reg_val (dbg_reg_val),
    .dbg_mem_sel (dbg_mem_sel),
    .dbg_mem_val (dbg_mem_val),
    .pc_out      (pc_out),
    .halted      (halted)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [15:0] i0;
    logic [15:0] i1;
    logic [15:0] i2;
    logic [15:0] i3;
    logic        is_mem;
    logic [3:0]  sel;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{16'h8190, 16'hBB10, 16'h92B0, 16'h0000, 1'b0, 4'd2,  32'h09, 8'd6},  // R6 r1 = 9
    '{16'h8190, 16'hBB10, 16'h92B0, 16'h0000, 1'b1, 4'hB,  32'h09, 8'd7},  // R7 word B = 9
    '{16'h8190, 16'hBB10, 16'h92B0, 16'h0000, 1'b0, 4'd1,  32'h09, 8'd5},  // R5 r0 = 9
    '{16'h91F0, 16'h8220, 16'h1120, 16'h0000, 1'b0, 4'd1,  32'h01, 8'd3},  // R3 FF+2 wraps
    '{16'h8130, 16'h8250, 16'h2120, 16'h0000, 1'b0, 4'd1,  32'hFE, 8'd3},  // R3 3-5 wraps
    '{16'h91A0, 16'h82F0, 16'h4120, 16'h0000, 1'b0, 4'd1,  32'h0A, 8'd3},  // R3 and
    '{16'h9190, 16'h8260, 16'h3120, 16'h0000, 1'b0, 4'd1,  32'h9F, 8'd3},  // R3 or
    '{16'h8470, 16'hA540, 16'h0000, 16'h0000, 1'b0, 4'd5,  32'h07, 8'd4},  // R4 mov r4,r3
    '{16'h8050, 16'h8160, 16'hA100, 16'h0000, 1'b0, 4'd1,  32'h00, 8'd2},  // R2 field 0
    '{16'h8F90, 16'hB2F0, 16'h0000, 16'h0000, 1'b1, 4'd2,  32'h09, 8'd2},  // R2 SP field 15
    '{16'h8E30, 16'hB3E0, 16'h0000, 16'h0000, 1'b1, 4'd3,  32'h03, 8'd2},  // R2 status field 14
    '{16'h8150, 16'hB810, 16'h0000, 16'h0000, 1'b1, 4'd8,  32'h05, 8'd7},  // R7 zero-extend
    '{16'h8110, 16'h7070, 16'h8120, 16'h8230, 1'b0, 4'd1,  32'h01, 8'd8},  // R8 skip
    '{16'h8110, 16'h7070, 16'h8120, 16'h8230, 1'b0, 4'd2,  32'h03, 8'd8},  // R8 target runs
    '{16'h7200, 16'h8150, 16'h0000, 16'h0000, 1'b0, 4'd1,  32'h00, 8'd10}, // R10 jump off end
    '{16'h8170, 16'h5000, 16'h0000, 16'h0000, 1'b1, 4'hF,  32'h07, 8'd9},  // R9 push store
    '{16'h8170, 16'h5000, 16'h8130, 16'h6000, 1'b0, 4'd1,  32'h07, 8'd9},  // R9 pop r0
    '{16'h8170, 16'h5000, 16'h8130, 16'h6000, 1'b0, 4'hF,  32'h00, 8'd9},  // R9 SP back
    '{16'h8140, 16'hC110, 16'hF120, 16'h0000, 1'b0, 4'd1,  32'h04, 8'd12}  // R12 unused ops
  };

  function automatic logic [31:0] data_word(input int k);
    return {24'hC0FFEE, 4'(k), 4'(k)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    halt_req = 1'b1;
    ld_en    = 1'b0;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic preload(input logic [15:0] p0, input logic [15:0] p1,
                         input logic [15:0] p2, input logic [15:0] p3);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      ld_en   = 1'b1;
      ld_addr = 4'(k);
      case (k)
        4:       ld_data = {16'h0, p0};
        5:       ld_data = {16'h0, p1};
        6:       ld_data = {16'h0, p2};
        7:       ld_data = {16'h0, p3};
        default: ld_data = data_word(k);
      endcase
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_to_halt(input string req);
    int n;
    halt_req = 1'b0;
    n = 0;
    while (!halted && n < 200) begin
      @(negedge clk);
      n++;
    end
    if (!halted) begin
      check(req, 32'(pc_out), 32'h10);
    end
  endtask

  task automatic read_reg(input logic [3:0] f, output logic [31:0] v);
    @(negedge clk);
    dbg_reg_sel = f;
    #1;
    v = {24'h0, dbg_reg_val};
  endtask

  task automatic read_mem(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    dbg_mem_sel = a;
    #1;
    v = dbg_mem_val;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    checks      = 0;
    errors      = 0;
    rst_n       = 1'b0;
    halt_req    = 1'b1;
    ld_en       = 1'b0;
    ld_addr     = '0;
    ld_data     = '0;
    dbg_reg_sel = '0;
    dbg_mem_sel = '0;

    // table-driven programs
    for (int i = 0; i < NV; i++) begin
      do_reset();
      preload(VEC[i].i0, VEC[i].i1, VEC[i].i2, VEC[i].i3);
      run_to_halt($sformatf("R%0d vec %0d no halt", VEC[i].req, i));
      if (VEC[i].is_mem) read_mem(VEC[i].sel, v);
      else               read_reg(VEC[i].sel, v);
      check($sformatf("R%0d vec %0d", VEC[i].req, i), v, VEC[i].exp);
    end

    // R13 and R1: reset state
    do_reset();
    check("R1 reset pc", 32'(pc_out), 32'h4);
    check("R10 not halted after reset", 32'(halted), 32'h0);
    read_reg(4'd1, v);
    check("R13 reg cleared", v, 32'h0);
    read_mem(4'd9, v);
    check("R13 mem cleared", v, 32'h0);

    // R13: load port
    preload(16'h8190, 16'hBB10, 16'h92B0, 16'h0000);
    read_mem(4'd9, v);
    check("R13 preload word", v, data_word(9));
    read_mem(4'd4, v);
    check("R13 preload program", v, 32'h8190);

    // R11: pause holds the core
    repeat (10) @(negedge clk);
    check("R11 pc held", 32'(pc_out), 32'h4);
    read_reg(4'd1, v);
    check("R11 r0 untouched", v, 32'h0);

    // R1: first pc move after fetch and execute edges
    @(negedge clk);
    halt_req = 1'b0;
    @(negedge clk);
    check("R1 pc after fetch edge", 32'(pc_out), 32'h4);
    @(negedge clk);
    check("R1 pc after execute edge", 32'(pc_out), 32'h5);
    halt_req = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 pc held mid-run", 32'(pc_out), 32'h5);

    run_to_halt("R10 no halt");
    check("R10 halted flag", 32'(halted), 32'h1);
    check("R10 pc past end", 32'(pc_out), 32'h10);
    repeat (6) @(negedge clk);
    check("R10 pc frozen", 32'(pc_out), 32'h10);
    read_reg(4'd0, v);
    check("R2 field 0 reads zero", v, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule